// File: doc/BRIEF.md
# Double-width multiplier with split result words

This unit multiplies two operands and returns the whole double-width product as two separate words: the low word and the high word. One request input selects whether both operands are read as unsigned numbers or as two's-complement signed numbers. A second request input selects the operand width: a full 64-bit multiply, or a 32-bit multiply carried inside the same 64-bit datapath.

A caller offers an operation with a valid/ready handshake. The operands, the width select and the signedness select are all taken in the cycle the handshake completes. The unit holds a single operation at a time and deasserts ready while that operation is in flight. Four cycles after acceptance it raises a one-cycle result strobe, with the low and high words on their own ports.

A caller that needs only the high part of a product reads the high word. A caller that needs only the low part reads the low word. Either word can be used alone, and the two words together always form one consistent product.

Top module: `dwmul_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready is 1, the result strobe is 0, and both result words are zero.
- R2: With width select 1 and signedness select 0, {high word, low word} equals the 128-bit unsigned product of the two 64-bit operands.
- R3: With width select 1 and signedness select 1, {high word, low word} equals the 128-bit two's-complement product of the two 64-bit operands.
- R4: For the same operands and the same width select, the low word is identical whether signedness select is 0 or 1.
- R5: With width select 0, only bits 31:0 of each operand are used. Bits 31:0 of the low word carry product bits 31:0, bits 31:0 of the high word carry product bits 63:32, and bits 63:32 of both words are zero. The signedness select applies at 32 bits.
- R6: The result strobe is high for exactly one cycle. It rises at the fourth rising clock edge after the edge that accepted the request.
- R7: Ready is low from the edge after acceptance until the result strobe cycle. A request offered while ready is low is ignored and produces no result.
- R8: The signed square of the most negative value gives a positive high word: 0x4000000000000000 with low word 0 in 64-bit mode, and 0x40000000 with low word 0 in 32-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is offered |
| req_ready_o | output | 1 | The unit can accept a request this cycle |
| req_a_i | input | 64 | First operand |
| req_b_i | input | 64 | Second operand |
| req_wide_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| req_signed_i | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| res_valid_o | output | 1 | One-cycle strobe marking a result |
| res_lo_o | output | 64 | Low word of the product |
| res_hi_o | output | 64 | High word of the product |

## Verification
The assertions on the result strobe and on ready assume that the operand and mode inputs only matter in a cycle where the valid/ready handshake completes. In any other cycle they may carry any value. The stimulus holds the request valid across whole busy periods with operands that change every cycle, so the busy-period assertions and the ignore check see live traffic. The 32-bit upper-zero assertion assumes nothing about the operands' upper halves, and the stimulus fills those bits with pseudo-random data in narrow mode.

// File: rtl/dwmul_pkg.sv
package dwmul_pkg;

    // Operand width selection carried along with an operation.
    typedef enum logic {
        WIDTH_32 = 1'b0,
        WIDTH_64 = 1'b1
    } width_e;

    // Interpretation of both operands.
    typedef enum logic {
        ARITH_UNS = 1'b0,
        ARITH_SGN = 1'b1
    } arith_e;

endpackage

// File: rtl/dwmul_opext.sv
// Turns one raw operand into an (XLEN+1)-bit two's-complement value.
// The extra bit lets a single signed multiplier serve both signedness modes.
module dwmul_opext
    import dwmul_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] op_i,
    input  width_e          wid_i,
    input  arith_e          ari_i,
    output logic [XLEN:0]   ext_o
);
    localparam int unsigned HLEN = XLEN / 2;

    logic fill;

    always_comb begin
        if (wid_i == WIDTH_64) begin
            fill  = (ari_i == ARITH_SGN) & op_i[XLEN-1];
            ext_o = {fill, op_i};
        end else begin
            fill  = (ari_i == ARITH_SGN) & op_i[HLEN-1];
            ext_o = {{(XLEN + 1 - HLEN){fill}}, op_i[HLEN-1:0]};
        end
    end

endmodule

// File: rtl/dwmul_mulcore.sv
// Signed multiply of two extended operands, truncated to the double width.
module dwmul_mulcore #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN:0]     a_i,
    input  logic [XLEN:0]     b_i,
    output logic [2*XLEN-1:0] prod_o
);
    localparam int unsigned PW = 2 * XLEN;

    logic signed [PW-1:0] a_w;
    logic signed [PW-1:0] b_w;

    always_comb begin
        a_w    = PW'($signed(a_i));
        b_w    = PW'($signed(b_i));
        prod_o = a_w * b_w;
    end

endmodule

// File: rtl/dwmul_fmt.sv
// Splits the double-width product into result words for the chosen width.
module dwmul_fmt
    import dwmul_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [2*XLEN-1:0] prod_i,
    input  width_e            wid_i,
    output logic [XLEN-1:0]   lo_o,
    output logic [XLEN-1:0]   hi_o
);
    localparam int unsigned HLEN = XLEN / 2;
    localparam int unsigned PW   = 2 * XLEN;

    always_comb begin
        if (wid_i == WIDTH_64) begin
            lo_o = prod_i[XLEN-1:0];
            hi_o = prod_i[PW-1:XLEN];
        end else begin
            lo_o = {{HLEN{1'b0}}, prod_i[HLEN-1:0]};
            hi_o = {{HLEN{1'b0}}, prod_i[XLEN-1:HLEN]};
        end
    end

endmodule

// File: rtl/dwmul_unit.sv
module dwmul_unit
    import dwmul_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned LAT  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    output logic            req_ready_o,
    input  logic [XLEN-1:0] req_a_i,
    input  logic [XLEN-1:0] req_b_i,
    input  logic            req_wide_i,
    input  logic            req_signed_i,
    output logic            res_valid_o,
    output logic [XLEN-1:0] res_lo_o,
    output logic [XLEN-1:0] res_hi_o
);
    localparam int unsigned HLEN = XLEN / 2;
    localparam int unsigned PW   = 2 * XLEN;
    localparam int unsigned EW   = XLEN + 1;
    localparam int unsigned CW   = $clog2(LAT + 1);
    localparam int unsigned AGEW = CW + 1;
    localparam logic [CW-1:0]   CNT_ONE  = CW'(1);
    localparam logic [CW-1:0]   CNT_LAST = CW'(LAT);
    localparam logic [AGEW-1:0] AGE_DONE = AGEW'(LAT + 1);

    typedef struct packed {
        logic [CW-1:0]   cnt;
        width_e          wid;
        logic [EW-1:0]   a_x;
        logic [EW-1:0]   b_x;
        logic [PW-1:0]   prod;
        logic [XLEN-1:0] lo;
        logic [XLEN-1:0] hi;
        logic            vld;
    } st_t;

    st_t st_d, st_q;

    width_e          wid_in;
    arith_e          ari_in;
    logic            accept;
    logic [XLEN-1:0] ops [2];
    logic [EW-1:0]   ext [2];
    logic [PW-1:0]   prod_w;
    logic [XLEN-1:0] lo_w;
    logic [XLEN-1:0] hi_w;

    assign wid_in = req_wide_i   ? WIDTH_64  : WIDTH_32;
    assign ari_in = req_signed_i ? ARITH_SGN : ARITH_UNS;
    assign ops[0] = req_a_i;
    assign ops[1] = req_b_i;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_ext
            dwmul_opext #(.XLEN(XLEN)) i_opext (
                .op_i  (ops[g]),
                .wid_i (wid_in),
                .ari_i (ari_in),
                .ext_o (ext[g])
            );
        end
    endgenerate

    dwmul_mulcore #(.XLEN(XLEN)) i_mulcore (
        .a_i    (st_q.a_x),
        .b_i    (st_q.b_x),
        .prod_o (prod_w)
    );

    dwmul_fmt #(.XLEN(XLEN)) i_fmt (
        .prod_i (st_q.prod),
        .wid_i  (st_q.wid),
        .lo_o   (lo_w),
        .hi_o   (hi_w)
    );

    assign req_ready_o = (st_q.cnt == '0);
    assign accept      = req_valid_i && req_ready_o;

    // Counter 0 = idle; 1 = operands held; product latched on leaving 1;
    // words formatted and strobe raised on leaving LAT.
    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.cnt == '0) begin
            if (accept) begin
                st_d.cnt = CNT_ONE;
                st_d.wid = wid_in;
                st_d.a_x = ext[0];
                st_d.b_x = ext[1];
            end
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            st_d.lo  = lo_w;
            st_d.hi  = hi_w;
            st_d.vld = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_ONE;
            if (st_q.cnt == CNT_ONE) begin
                st_d.prod = prod_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.vld;
    assign res_lo_o    = st_q.lo;
    assign res_hi_o    = st_q.hi;

    // Independent age counter for checking the result latency.
    logic [AGEW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (accept) begin
            age_q <= AGEW'(1);
        end else if (age_q != '0 && age_q < AGE_DONE) begin
            age_q <= age_q + AGEW'(1);
        end
    end

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> age_q == AGE_DONE);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready_o);

    // R7
    result_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid_o) |-> $past(!req_ready_o));

    // R5
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && st_q.wid == WIDTH_32) |->
            (res_lo_o[XLEN-1:HLEN] == '0 && res_hi_o[XLEN-1:HLEN] == '0));

endmodule

// File: tb/test_dwmul_unit.sv
module test_dwmul_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [63:0] req_a_i = '0;
    logic [63:0] req_b_i = '0;
    logic        req_wide_i = 1'b0;
    logic        req_signed_i = 1'b0;
    logic        res_valid_o;
    logic [63:0] res_lo_o;
    logic [63:0] res_hi_o;

    always #4 clk = ~clk;   // 125 MHz

    dwmul_unit i_dwmul_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .req_a_i      (req_a_i),
        .req_b_i      (req_b_i),
        .req_wide_i   (req_wide_i),
        .req_signed_i (req_signed_i),
        .res_valid_o  (res_valid_o),
        .res_lo_o     (res_lo_o),
        .res_hi_o     (res_hi_o)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    // Reference model state
    int          m_cnt = 0;
    logic [63:0] q_lo [$];
    logic [63:0] q_hi [$];
    string       q_tag [$];
    string       tag_override = "";
    logic [63:0] seen_lo = '0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    function automatic void ref_mul(input logic [63:0] a, input logic [63:0] b,
                                    input bit w, input bit s,
                                    output logic [63:0] lo, output logic [63:0] hi);
        logic [127:0] p;
        logic [63:0]  q;
        if (w) begin
            if (s) p = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
            else   p = {64'b0, a} * {64'b0, b};
            lo = p[63:0];
            hi = p[127:64];
        end else begin
            if (s) q = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
            else   q = {32'b0, a[31:0]} * {32'b0, b[31:0]};
            lo = {32'b0, q[31:0]};
            hi = {32'b0, q[63:32]};
        end
    endfunction

    function automatic logic [63:0] next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, let the rising edge pass, update
    // the model for it, then compare at the next falling edge.
    task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b,
                        input bit w, input bit s);
        logic [63:0] lo, hi;
        bit          exp_vld;
        logic [63:0] exp_lo, exp_hi;
        string       tag;
        req_valid_i  = v;
        req_a_i      = a;
        req_b_i      = b;
        req_wide_i   = w;
        req_signed_i = s;
        @(posedge clk);
        @(negedge clk);
        exp_vld = 1'b0;
        exp_lo  = '0;
        exp_hi  = '0;
        tag     = "R6";
        if (m_cnt == 0) begin
            if (v) begin
                ref_mul(a, b, w, s, lo, hi);
                q_lo.push_back(lo);
                q_hi.push_back(hi);
                if (tag_override != "") q_tag.push_back(tag_override);
                else if (!w)            q_tag.push_back("R5");
                else if (s)             q_tag.push_back("R3");
                else                    q_tag.push_back("R2");
                m_cnt = 1;
            end
        end else if (m_cnt == 4) begin
            m_cnt   = 0;
            exp_vld = 1'b1;
            exp_lo  = q_lo.pop_front();
            exp_hi  = q_hi.pop_front();
            tag     = q_tag.pop_front();
        end else begin
            m_cnt = m_cnt + 1;
        end
        check(req_ready_o == (m_cnt == 0), "R7", "ready",
              64'(req_ready_o), 64'(m_cnt == 0));
        check(res_valid_o == exp_vld, "R6", "result strobe",
              64'(res_valid_o), 64'(exp_vld));
        if (exp_vld && res_valid_o) begin
            check(res_lo_o == exp_lo, tag, "low word", res_lo_o, exp_lo);
            check(res_hi_o == exp_hi, tag, "high word", res_hi_o, exp_hi);
            seen_lo = res_lo_o;
        end
    endtask

    task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                           input bit w, input bit s);
        step(1'b1, a, b, w, s);
        for (int i = 0; i < 5; i++) step(1'b0, next_rng(), next_rng(), ~w, ~s);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] lo_uns;
        // R1: reset state, during and right after reset
        repeat (3) @(negedge clk);
        check(req_ready_o == 1'b1, "R1", "ready in reset", 64'(req_ready_o), 64'd1);
        check(res_valid_o == 1'b0, "R1", "strobe in reset", 64'(res_valid_o), 64'd0);
        check(res_lo_o == '0, "R1", "low word in reset", res_lo_o, 64'd0);
        check(res_hi_o == '0, "R1", "high word in reset", res_hi_o, 64'd0);
        rst_n = 1'b1;
        step(1'b0, '0, '0, 1'b0, 1'b0);
        check(res_lo_o == '0 && res_hi_o == '0, "R1", "words after reset",
              res_lo_o | res_hi_o, 64'd0);

        // R2: unsigned 64-bit corner values
        run_one(64'd7, 64'd9, 1'b1, 1'b0);
        run_one('1, '1, 1'b1, 1'b0);
        run_one(64'h8000_0000_0000_0000, 64'd2, 1'b1, 1'b0);

        // R3: signed 64-bit sign combinations
        run_one('1, '1, 1'b1, 1'b1);
        run_one('1, 64'd1, 1'b1, 1'b1);
        run_one(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 1'b1);

        // R8: most negative value squared
        tag_override = "R8";
        run_one(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b1);
        check(res_hi_o == 64'h4000_0000_0000_0000 && res_lo_o == '0, "R8",
              "wide min squared", res_hi_o, 64'h4000_0000_0000_0000);
        run_one(64'hDEAD_BEEF_8000_0000, 64'h1234_5678_8000_0000, 1'b0, 1'b1);
        check(res_hi_o == 64'h0000_0000_4000_0000 && res_lo_o == '0, "R8",
              "narrow min squared", res_hi_o, 64'h0000_0000_4000_0000);
        tag_override = "";

        // R5: narrow mode with junk in the upper operand halves
        run_one(64'hFFFF_0000_FFFF_FFFF, 64'hAAAA_5555_FFFF_FFFF, 1'b0, 1'b0);
        run_one(64'hFFFF_0000_FFFF_FFFF, 64'hAAAA_5555_0000_0003, 1'b0, 1'b1);

        // R4: low word independent of signedness
        run_one(64'hF123_4567_89AB_CDEF, 64'h8765_4321_0FED_CBA9, 1'b1, 1'b0);
        lo_uns = seen_lo;
        run_one(64'hF123_4567_89AB_CDEF, 64'h8765_4321_0FED_CBA9, 1'b1, 1'b1);
        check(seen_lo == lo_uns, "R4", "low word across signedness", seen_lo, lo_uns);

        // R7: request held valid with changing operands through busy periods
        for (int i = 0; i < 600; i++) begin
            logic [63:0] r;
            r = next_rng();
            step(r[0] | r[1], next_rng(), next_rng(), r[2], r[3]);
        end
        for (int i = 0; i < 6; i++) step(1'b0, '0, '0, 1'b0, 1'b0);
        check(q_lo.size() == 0, "R7", "pending results drained",
              64'(q_lo.size()), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule